// File: doc/BRIEF.md
# Descriptor Ring Position Counter

This block gives a DMA engine the index of the current entry in a circular ring of transfer descriptors, and tells it when the ring has come back to the start. Software sets the ring size by writing the negative of the entry count, in two's complement, to a 16-bit length register. A 16-bit position register counts upward towards zero. A position of zero marks the last entry in the ring. Each advance strobe moves the position by one. An advance taken at the last entry restarts the count and gives a one-cycle wrap pulse.

The two registers sit behind a 32-bit register port. The top half of each word is ignored on write and reads back as zero. A small control state machine has two states, ST_RUN and ST_HALT. Its transition T_HOLD (ST_RUN to ST_HALT) is taken on the clock where STOP or the suspend input is sampled high. Its transition T_RELEASE (ST_HALT to ST_RUN) is taken on the clock where both are sampled low. The machine stays in its state on any other clock. Register writes take effect only in ST_HALT. Reset puts the machine in ST_RUN and clears the wrap pulse. Reset and STOP do not change the length or the position, which hold their values across both. At power-up the length is 0xFFFF and the position is 0x0000.

On a restart the position is loaded with the length value plus one. Zero is then reached after exactly as many advances as the ring has entries, less one.

Top module: `desc_ring_pos`

## Requirements
- R1: Reset forces `wrap` low and the control machine to ST_RUN. Reset leaves the length and position registers unchanged, so a write in the first cycles after reset is ignored.
- R2: A write while the machine is in ST_RUN changes neither register.
- R3: `reg_sel` = 0 selects the length register and `reg_sel` = 1 selects the position register. Bits 15:0 of `reg_wdata` are stored. Bits 31:16 are ignored, and `reg_rdata` returns the selected value zero-extended.
- R4: An advance taken while the position is not zero adds one to the position and leaves `wrap` low in the next cycle.
- R5: An advance taken while the position is zero loads the position with the length plus one (mod 2^16). It also raises `wrap` for exactly the next cycle.
- R6: `desc_idx` equals position minus length minus one (mod 2^16). The first entry after a restart therefore reports index 0.
- R7: `last_desc` is high exactly when the position is zero. `desc_idx` then equals the entry count minus one, which is the bitwise inverse of the length.
- R8: With length 0xFFFF (one entry), every advance is a wrap, and `desc_idx` stays 0 with `last_desc` high.
- R9: A position write and an advance in the same cycle store the written value and give no wrap pulse.
- R10: With length 0x0001 (65535 entries), the last entry reports index 65534, and the restart value is 0x0002.
- R11: Writes are accepted from the clock after STOP or suspend is sampled high. They are refused again from the clock after both are sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control machine and the wrap pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = length register, 1 = position register |
| reg_wdata | input | 32 | Write data; bits 31:16 ignored |
| reg_rdata | output | 32 | Selected register, zero-extended |
| ctl_stop | input | 1 | STOP control status |
| ctl_susp | input | 1 | Suspend control status |
| adv | input | 1 | Advance to the next descriptor |
| wrap | output | 1 | One-cycle pulse after an advance taken at the last entry |
| desc_idx | output | 16 | Current descriptor index, 0 = first |
| last_desc | output | 1 | Current entry is the last in the ring |

## Verification
A four-entry ring is walked twice past its restart point. This separates a plain step from a reload, and a reload to the length value from a reload to the length plus one. It also checks that the wrap pulse lasts one cycle only. A one-entry ring and a 65535-entry ring probe the two ends of the range, where an off-by-one in the restart value or in the index subtraction would be seen. Writes are issued while running, on the very edge that STOP rises, after STOP falls and on the same edge as an advance. These cases separate a write gate on the registered machine state from a gate on the raw inputs, and a write that beats the advance from one that loses to it.

// File: rtl/drp_pkg.sv
package drp_pkg;

    localparam int unsigned POS_W = 16;
    localparam int unsigned BUS_W = 32;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } ring_st_e;

    typedef enum logic {
        SEL_LEN = 1'b0,
        SEL_POS = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/drp_ctl_fsm.sv
module drp_ctl_fsm
    import drp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctl_stop,
    input  logic     ctl_susp,
    output ring_st_e st,
    output logic     wr_open
);

    ring_st_e st_q;
    ring_st_e st_d;
    logic     hold_req;

    assign hold_req = ctl_stop | ctl_susp;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: T_HOLD and T_RELEASE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  if (hold_req)  st_d = ST_HALT;
            ST_HALT: if (!hold_req) st_d = ST_RUN;
            default: st_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        wr_open = 1'b0;
        unique case (st_q)
            ST_RUN:  wr_open = 1'b0;
            ST_HALT: wr_open = 1'b1;
            default: wr_open = 1'b0;
        endcase
    end

    assign st = st_q;

endmodule

// File: rtl/drp_len_reg.sv
module drp_len_reg #(
    parameter int unsigned POS_W = 16
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [POS_W-1:0] wdata,
    output logic [POS_W-1:0] len
);

    // power-up value: a ring of one entry; no reset term by intent
    logic [POS_W-1:0] len_r = '1;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            len_r <= wdata;
        end
    end

    assign len = len_r;

endmodule

// File: rtl/drp_pos_cnt.sv
module drp_pos_cnt #(
    parameter int unsigned POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [POS_W-1:0] wdata,
    input  logic             adv,
    input  logic [POS_W-1:0] len,
    output logic [POS_W-1:0] pos,
    output logic             wrap
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [POS_W-1:0] pos_r = '0;
    logic [POS_W-1:0] pos_d;
    logic [POS_W-1:0] restart;
    logic             at_last;
    logic             wrap_r;
    logic             wrap_d;

    assign at_last = (pos_r == '0);
    assign restart = len + ONE;

    always_comb begin
        pos_d  = pos_r;
        wrap_d = 1'b0;
        if (wr_en) begin
            pos_d = wdata;
        end else if (adv) begin
            if (at_last) begin
                pos_d  = restart;
                wrap_d = 1'b1;
            end else begin
                pos_d = pos_r + ONE;
            end
        end
    end

    // position: survives reset
    always_ff @(posedge clk) begin
        pos_r <= pos_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrap_r <= 1'b0;
        end else begin
            wrap_r <= wrap_d;
        end
    end

    assign pos  = pos_r;
    assign wrap = wrap_r;

endmodule

// File: rtl/drp_index_calc.sv
module drp_index_calc #(
    parameter int unsigned POS_W = 16
) (
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] len,
    output logic [POS_W-1:0] idx,
    output logic             last
);

    assign idx  = pos - len - POS_W'(1);
    assign last = (pos == '0);

endmodule

// File: rtl/desc_ring_pos.sv
module desc_ring_pos
    import drp_pkg::*;
#(
    parameter int unsigned POS_W = drp_pkg::POS_W,
    parameter int unsigned BUS_W = drp_pkg::BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic             ctl_stop,
    input  logic             ctl_susp,
    input  logic             adv,
    output logic             wrap,
    output logic [POS_W-1:0] desc_idx,
    output logic             last_desc
);

    ring_st_e         st;
    logic             wr_open;
    logic             len_we;
    logic             pos_we;
    logic [POS_W-1:0] wr_field;
    logic [POS_W-1:0] len_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] rd_field;
    reg_sel_e         sel;

    assign sel      = reg_sel_e'(reg_sel);
    assign wr_field = reg_wdata[POS_W-1:0];
    assign len_we   = wr_open & reg_wr & (sel == SEL_LEN);
    assign pos_we   = wr_open & reg_wr & (sel == SEL_POS);

    drp_ctl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_stop (ctl_stop),
        .ctl_susp (ctl_susp),
        .st       (st),
        .wr_open  (wr_open)
    );

    drp_len_reg #(.POS_W(POS_W)) u_len (
        .clk   (clk),
        .wr_en (len_we),
        .wdata (wr_field),
        .len   (len_q)
    );

    drp_pos_cnt #(.POS_W(POS_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (pos_we),
        .wdata (wr_field),
        .adv   (adv),
        .len   (len_q),
        .pos   (pos_q),
        .wrap  (wrap)
    );

    drp_index_calc #(.POS_W(POS_W)) u_idx (
        .pos  (pos_q),
        .len  (len_q),
        .idx  (desc_idx),
        .last (last_desc)
    );

    always_comb begin
        rd_field = len_q;
        unique case (sel)
            SEL_LEN: rd_field = len_q;
            SEL_POS: rd_field = pos_q;
            default: rd_field = len_q;
        endcase
    end

    generate
        if (BUS_W > POS_W) begin : g_wide
            logic unused_hi;
            assign unused_hi = ^reg_wdata[BUS_W-1:POS_W];
            assign reg_rdata = {{(BUS_W-POS_W){1'b0}}, rd_field};
        end else begin : g_exact
            assign reg_rdata = rd_field;
        end
    endgenerate

endmodule

// File: rtl/drp_checker.sv
module drp_checker #(
    parameter int unsigned POS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic             st_halt,
    input logic [POS_W-1:0] pos,
    input logic [POS_W-1:0] len,
    input logic             wrap,
    input logic [POS_W-1:0] desc_idx,
    input logic             last_desc
);

    logic pos_wr;
    assign pos_wr = st_halt & reg_wr & reg_sel;

    AST_LOCKED_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        !st_halt |=> $stable(len)); // R2
    AST_LOCKED_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_halt && !adv) |=> $stable(pos)); // R2
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && pos != '0 && !pos_wr) |=> (pos == $past(pos) + POS_W'(1)) && !wrap); // R4
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && pos == '0 && !pos_wr) |=> (pos == $past(len) + POS_W'(1)) && wrap); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_wr && adv) |=> !wrap); // R9
    AST_FIRST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (desc_idx == '0)); // R6
    AST_LAST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        last_desc |-> (desc_idx == ~len)); // R7

endmodule

bind desc_ring_pos drp_checker #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .st_halt   (wr_open),
    .pos       (pos_q),
    .len       (len_q),
    .wrap      (wrap),
    .desc_idx  (desc_idx),
    .last_desc (last_desc)
);

// File: tb/desc_ring_pos_test.sv
module desc_ring_pos_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ctl_stop = 1'b0;
    logic        ctl_susp = 1'b0;
    logic        adv = 1'b0;
    logic        wrap;
    logic [15:0] desc_idx;
    logic        last_desc;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_ring_pos uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctl_stop  (ctl_stop),
        .ctl_susp  (ctl_susp),
        .adv       (adv),
        .wrap      (wrap),
        .desc_idx  (desc_idx),
        .last_desc (last_desc)
    );

    // {adv, position, index, last, wrap} for a four-entry ring
    localparam logic [34:0] VEC [6] = '{
        {1'b1, 16'hFFFE, 16'd1, 1'b0, 1'b0},
        {1'b1, 16'hFFFF, 16'd2, 1'b0, 1'b0},
        {1'b1, 16'h0000, 16'd3, 1'b1, 1'b0},
        {1'b1, 16'hFFFD, 16'd0, 1'b0, 1'b1},
        {1'b0, 16'hFFFD, 16'd0, 1'b0, 1'b0},
        {1'b1, 16'hFFFE, 16'd1, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        reg_wr    = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state and power-up contents
        check("R1 wrap after reset", {31'd0, wrap}, 32'd0);
        rd(1'b0, v); check("R1 length power-up", v, 32'h0000_FFFF);
        rd(1'b1, v); check("R1 position power-up", v, 32'h0000_0000);

        // program a four-entry ring
        ctl_stop = 1'b1; tick();
        wr(1'b0, 32'h0000_FFFC);
        wr(1'b1, 32'h0000_FFFD);
        ctl_stop = 1'b0; tick();
        check("R6 first index", {16'd0, desc_idx}, 32'd0);

        // R4 R5 R6 R7: table walk
        for (int i = 0; i < 6; i++) begin
            adv = VEC[i][34];
            tick();
            adv = 1'b0;
            rd(1'b1, v);
            check($sformatf("R4/R5 vec%0d position", i), v, {16'd0, VEC[i][33:18]});
            check($sformatf("R6 vec%0d index", i), {16'd0, desc_idx}, {16'd0, VEC[i][17:2]});
            check($sformatf("R7 vec%0d last", i), {31'd0, last_desc}, {31'd0, VEC[i][1]});
            check($sformatf("R5 vec%0d wrap", i), {31'd0, wrap}, {31'd0, VEC[i][0]});
        end

        // R2: writes while running
        wr(1'b0, 32'h0000_1234);
        rd(1'b0, v); check("R2 length locked", v, 32'h0000_FFFC);
        wr(1'b1, 32'h0000_0000);
        rd(1'b1, v); check("R2 position locked", v, 32'h0000_FFFE);

        // R11: write on the edge STOP rises is refused
        ctl_stop = 1'b1;
        wr(1'b0, 32'h0000_FFF0);
        rd(1'b0, v); check("R11 write on STOP edge", v, 32'h0000_FFFC);

        // R3: upper bits ignored, read zero-extended
        wr(1'b0, 32'hABCD_FFF8);
        rd(1'b0, v); check("R3 upper bits", v, 32'h0000_FFF8);

        // R9: position write beats advance
        wr(1'b1, 32'h0000_0000);
        adv = 1'b1;
        wr(1'b1, 32'h0000_0005);
        adv = 1'b0;
        rd(1'b1, v); check("R9 written value kept", v, 32'h0000_0005);
        check("R9 no wrap", {31'd0, wrap}, 32'd0);

        // R11: refused after release
        ctl_stop = 1'b0; tick();
        wr(1'b0, 32'h0000_0000);
        rd(1'b0, v); check("R11 refused after release", v, 32'h0000_FFF8);

        // R11: suspend alone opens writes; R8 single-entry ring
        ctl_susp = 1'b1; tick();
        wr(1'b0, 32'h0000_FFFF);
        wr(1'b1, 32'h0000_0000);
        ctl_susp = 1'b0; tick();
        rd(1'b0, v); check("R11 suspend opens", v, 32'h0000_FFFF);
        for (int k = 0; k < 3; k++) begin
            adv = 1'b1; tick(); adv = 1'b0;
            check($sformatf("R8 wrap %0d", k), {31'd0, wrap}, 32'd1);
            check($sformatf("R8 index %0d", k), {16'd0, desc_idx}, 32'd0);
            check($sformatf("R8 last %0d", k), {31'd0, last_desc}, 32'd1);
        end
        tick();
        check("R5 wrap single cycle", {31'd0, wrap}, 32'd0);

        // R10: largest ring
        ctl_susp = 1'b1; tick();
        wr(1'b0, 32'h0000_0001);
        wr(1'b1, 32'h0000_0000);
        ctl_susp = 1'b0; tick();
        check("R10 last index", {16'd0, desc_idx}, 32'd65534);
        check("R10 last flag", {31'd0, last_desc}, 32'd1);
        adv = 1'b1; tick(); adv = 1'b0;
        rd(1'b1, v); check("R10 restart value", v, 32'h0000_0002);
        check("R10 restart index", {16'd0, desc_idx}, 32'd0);
        check("R10 wrap", {31'd0, wrap}, 32'd1);

        // R1: contents survive reset, machine back in run state
        ctl_stop = 1'b1; tick();
        rst_n = 1'b0; tick(); tick();
        rst_n = 1'b1;
        ctl_stop = 1'b0;
        rd(1'b0, v); check("R1 length kept", v, 32'h0000_0001);
        rd(1'b1, v); check("R1 position kept", v, 32'h0000_0002);
        check("R1 wrap cleared", {31'd0, wrap}, 32'd0);
        wr(1'b0, 32'h0000_FFFF);
        rd(1'b0, v); check("R1 run state after reset", v, 32'h0000_0001);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule